// File: doc/BRIEF.md
# Dual-Rail Steering Demultiplexer and Merge

This block sends one dual-rail DATA wavefront into exactly one of several downstream branches, picked by a dual-rail select word, and then joins the branch results back into a single dual-rail result. Branches that are not picked never see DATA. Their rails stay NULL for the whole wavefront, so they make no transitions. Every computation follows the pattern DATA, then NULL, then the next DATA. The NULL wavefront clears every branch.

The block is built from three parts.

- A select decoder turns the select pairs into single-rail branch enables.
- A grid of state-holding threshold-2-of-2 gates admits each data rail into a branch only while that branch's enable is asserted. There is one gate per rail per branch.
- A rail-by-rail OR merge recombines the branch outputs.

The downstream components are outside the block. Each is replaced by a wiring stub: branch k rotates the rail positions left by k. This lets the picked branch be seen at the result port.

Each gate is a two-state machine, clocked so that it can be simulated and synthesised:

- **TH_LOW** moves to **TH_HIGH** on the *set* transition (both inputs asserted).
- **TH_HIGH** moves to **TH_LOW** on the *clear* transition (both inputs deasserted).
- Any other input combination is the *hold* transition, and the state stays where it is.

The result is driven from the gate states through combinational stubs and the merge. It therefore follows an input change one clock edge later.

Top module: `ncl_steer_unit`

## Requirements
- R1: While rst_n is low, every gate is in TH_LOW and res_t and res_f are all zero. They remain zero in the first cycle after release, as long as the inputs are NULL.
- R2: Branch enable k is asserted only when every select pair carries DATA and the select value equals k. Select bit j reads 1 when pick_t[j]=1 and pick_f[j]=0, and reads 0 for the opposite pattern. A select pair that is still NULL (both rails 0) enables no branch. At most one enable is asserted at a time.
- R3: A gate output asserts after an edge at which both its inputs are 1. It deasserts after an edge at which both are 0. Otherwise it holds its value.
- R4: During a DATA wavefront at most one branch carries any asserted rail. All other branches stay NULL.
- R5: Branch k passes data bit (i-k) mod WIDTH to result bit i, so the result equals the data rotated left by the select value.
- R6: Each result rail is the OR of the same rail across all branches. For a data value v, the complete result satisfies res_f = ~res_t.
- R7: Data and select may arrive in any order, including one data bit at a time. The result stays NULL until both are complete. It is complete one clock edge after the last arrival.
- R8: When the data and select are all NULL, the result is all NULL after the next clock edge.
- R9: If the data returns to NULL while the select still carries DATA, the result keeps its DATA value. It clears only after the select also returns to NULL.
- R10: For legal inputs (no pair with both rails at 1), no result pair ever has both rails at 1. The bench flags any such pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the gate states |
| rst_n | input | 1 | Active-low reset; forces all gates to TH_LOW |
| data_t | input | WIDTH | True rails of the data word |
| data_f | input | WIDTH | False rails of the data word |
| pick_t | input | SEL_W | True rails of the branch select |
| pick_f | input | SEL_W | False rails of the branch select |
| res_t | output | WIDTH | True rails of the merged result |
| res_f | output | WIDTH | False rails of the merged result |

## Verification
The following are checked on every cycle by the assertions:

- the set, clear and hold behaviour of each gate;
- that at most one branch enable is active;
- that an incomplete select enables nothing;
- that at most one branch carries DATA;
- that no result pair shows both rails;
- that an all-NULL input clears the result.

Other behaviour is shown only by the bench's scenarios:

- the rotation that identifies which branch was picked;
- completion after out-of-order or bit-by-bit arrival;
- the output staying NULL while the select is missing;
- the hold of the result when the data returns to NULL before the select.

// File: rtl/ncl_steer_pkg.sv
package ncl_steer_pkg;

    typedef enum logic {
        TH_LOW  = 1'b0,
        TH_HIGH = 1'b1
    } th_state_e;

    // Source bit index for a left rotation by sh positions on a w-bit word
    function automatic int rot_src(input int i, input int sh, input int w);
        return (i + w - (sh % w)) % w;
    endfunction

endpackage

// File: rtl/ncl_sel_decoder.sv
module ncl_sel_decoder #(
    parameter int SEL_W = 2,
    localparam int NUM_BR = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  pick_t,
    input  logic [SEL_W-1:0]  pick_f,
    output logic [NUM_BR-1:0] en
);

    for (genvar k = 0; k < NUM_BR; k++) begin : g_dec
        logic hit;
        always_comb begin
            hit = 1'b1;
            for (int j = 0; j < SEL_W; j++) begin
                if (((k >> j) & 1) == 1) hit = hit & pick_t[j];
                else                     hit = hit & pick_f[j];
            end
        end
        assign en[k] = hit;
    end

    // R2: enables are mutually exclusive
    p_single_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en));

    // R2: an incomplete select enables nothing
    p_partial_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pick_t | pick_f) != {SEL_W{1'b1}}) |-> (en == '0));

endmodule

// File: rtl/ncl_th22_gate.sv
module ncl_th22_gate
    import ncl_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic q
);

    th_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TH_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_LOW:  if (a && b)   state_d = TH_HIGH;
            TH_HIGH: if (!a && !b) state_d = TH_LOW;
            default:               state_d = TH_LOW;
        endcase
    end

    always_comb q = (state_q == TH_HIGH);

    // R3: set, clear and hold behaviour of the threshold-2-of-2 gate
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a && b) |=> q);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!a && !b) |=> !q);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a != b) |=> $stable(q));

endmodule

// File: rtl/ncl_branch_stub.sv
module ncl_branch_stub
    import ncl_steer_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SHIFT = 0
) (
    input  logic [WIDTH-1:0] x_t,
    input  logic [WIDTH-1:0] x_f,
    output logic [WIDTH-1:0] y_t,
    output logic [WIDTH-1:0] y_f
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_wire
        localparam int SRC = rot_src(i, SHIFT, WIDTH);
        assign y_t[i] = x_t[SRC];
        assign y_f[i] = x_f[SRC];
    end

endmodule

// File: rtl/ncl_or_merge.sv
module ncl_or_merge #(
    parameter int WIDTH  = 8,
    parameter int NUM_BR = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BR-1:0][WIDTH-1:0]  br_t,
    input  logic [NUM_BR-1:0][WIDTH-1:0]  br_f,
    output logic [WIDTH-1:0]              res_t,
    output logic [WIDTH-1:0]              res_f
);

    logic [NUM_BR-1:0] active;

    always_comb begin
        res_t = '0;
        res_f = '0;
        for (int k = 0; k < NUM_BR; k++) begin
            res_t     = res_t | br_t[k];
            res_f     = res_f | br_f[k];
            active[k] = (|br_t[k]) | (|br_f[k]);
        end
    end

    // R4: only one branch may carry DATA at any time
    p_one_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active));

    // R10: no result pair with both rails asserted
    p_pair_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_t & res_f) == '0);

endmodule

// File: rtl/ncl_steer_unit.sv
module ncl_steer_unit #(
    parameter int WIDTH = 8,
    parameter int SEL_W = 2,
    localparam int NUM_BR = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_t,
    input  logic [WIDTH-1:0] data_f,
    input  logic [SEL_W-1:0] pick_t,
    input  logic [SEL_W-1:0] pick_f,
    output logic [WIDTH-1:0] res_t,
    output logic [WIDTH-1:0] res_f
);

    logic [NUM_BR-1:0]             en;
    logic [NUM_BR-1:0][WIDTH-1:0]  g_t, g_f;
    logic [NUM_BR-1:0][WIDTH-1:0]  s_t, s_f;

    ncl_sel_decoder #(.SEL_W(SEL_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .pick_t (pick_t),
        .pick_f (pick_f),
        .en     (en)
    );

    for (genvar k = 0; k < NUM_BR; k++) begin : g_branch
        for (genvar i = 0; i < WIDTH; i++) begin : g_rail
            ncl_th22_gate u_gt (
                .clk(clk), .rst_n(rst_n), .a(data_t[i]), .b(en[k]), .q(g_t[k][i])
            );
            ncl_th22_gate u_gf (
                .clk(clk), .rst_n(rst_n), .a(data_f[i]), .b(en[k]), .q(g_f[k][i])
            );
        end

        ncl_branch_stub #(.WIDTH(WIDTH), .SHIFT(k)) u_stub (
            .x_t (g_t[k]),
            .x_f (g_f[k]),
            .y_t (s_t[k]),
            .y_f (s_f[k])
        );
    end

    ncl_or_merge #(.WIDTH(WIDTH), .NUM_BR(NUM_BR)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .br_t  (s_t),
        .br_f  (s_f),
        .res_t (res_t),
        .res_f (res_f)
    );

    // R8: an all-NULL input clears the result after one edge
    p_null_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_t | data_f) == '0 && (pick_t | pick_f) == '0) |=> ((res_t | res_f) == '0));

    // R7: with no branch enabled, a NULL result stays NULL
    p_no_enable_stays_null_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((res_t | res_f) == '0 && en == '0) |=> ((res_t | res_f) == '0));

endmodule

// File: tb/ncl_steer_unit_tb_top.sv
module ncl_steer_unit_tb_top;

    localparam int W  = 8;
    localparam int SW = 2;
    localparam int NB = 1 << SW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  data_t, data_f;
    logic [SW-1:0] pick_t, pick_f;
    logic [W-1:0]  res_t, res_f;

    always #5 clk = ~clk;

    ncl_steer_unit #(.WIDTH(W), .SEL_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .data_t(data_t), .data_f(data_f),
        .pick_t(pick_t), .pick_f(pick_f),
        .res_t(res_t), .res_f(res_f)
    );

    typedef struct {
        logic [W-1:0] val;
        string        tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int sh);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[(i + W - (sh % W)) % W];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic put_data(input logic [W-1:0] v);
        data_t = v;
        data_f = ~v;
    endtask

    task automatic put_pick(input int s);
        pick_t = SW'(s);
        pick_f = ~SW'(s);
    endtask

    task automatic push_exp(input logic [W-1:0] v, input string tag);
        exp_item_t it;
        it.val = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic drain(input string tag);
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (exp_q.size() == 0) break;
        end
        if (exp_q.size() != 0) begin
            chk(1'b0, tag, 32'(exp_q.size()), 32'd0);
            exp_q.delete();
        end
    endtask

    task automatic go_null(input string tag);
        @(negedge clk);
        data_t = '0; data_f = '0; pick_t = '0; pick_f = '0;
        @(negedge clk);
        chk((res_t | res_f) == '0, tag, 32'({res_t, res_f}), 32'd0);
    endtask

    // Monitor: pops an expected item at each rise of result completeness
    bit was_complete = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if ((res_t & res_f) != '0)
                    chk(1'b0, "R10 pair with both rails", 32'({res_t, res_f}), 32'd0);
                if ((&(res_t ^ res_f)) && !was_complete) begin
                    if (exp_q.size() > 0) begin
                        exp_item_t it;
                        it = exp_q.pop_front();
                        chk(res_t == it.val, it.tag, 32'(res_t), 32'(it.val));
                        chk(res_f == ~it.val, "R6 false rails", 32'(res_f), 32'(~it.val));
                    end else begin
                        chk(1'b0, "R4 unexpected completion", 32'(res_t), 32'd0);
                    end
                end
                was_complete = &(res_t ^ res_f);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        data_t = '0; data_f = '0; pick_t = '0; pick_f = '0;
        repeat (3) @(negedge clk);
        chk((res_t | res_f) == '0, "R1 reset null", 32'({res_t, res_f}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk((res_t | res_f) == '0, "R1 after release", 32'({res_t, res_f}), 32'd0);

        // Select first, then data: branch 0 passes unrotated
        @(negedge clk);
        put_pick(0);
        push_exp(rotl(8'hA5, 0), "R5 branch0");
        @(negedge clk);
        put_data(8'hA5);
        drain("R5 branch0 timeout");
        go_null("R8 clear after A");

        // Data first: result must stay NULL until select completes
        @(negedge clk);
        put_data(8'h5A);
        repeat (2) @(negedge clk);
        chk((res_t | res_f) == '0, "R7 data without select", 32'({res_t, res_f}), 32'd0);
        push_exp(rotl(8'h5A, 2), "R7 late select");
        put_pick(2);
        drain("R7 late select timeout");
        go_null("R8 clear after B");

        // Bit-by-bit arrival on branch 3
        @(negedge clk);
        put_pick(3);
        push_exp(rotl(8'h3C, 3), "R7 bitwise arrival");
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            data_t[i] = 1'b0 ^ ((8'h3C >> i) & 1);
            data_f[i] = ~data_t[i];
        end
        drain("R7 bitwise timeout");
        go_null("R8 clear after C");

        // Each branch in turn with a single set bit
        for (int k = 0; k < NB; k++) begin
            @(negedge clk);
            put_pick(k);
            push_exp(rotl(8'h01, k), "R2 R5 branch sweep");
            @(negedge clk);
            put_data(8'h01);
            drain("R5 sweep timeout");
            go_null("R8 clear in sweep");
        end

        // All DATA0 on branch 1
        @(negedge clk);
        put_data(8'h00);
        put_pick(1);
        push_exp(8'h00, "R6 all zero data");
        drain("R6 zero timeout");
        go_null("R8 clear after D");

        // Data returns to NULL while select holds: result held
        @(negedge clk);
        put_pick(2);
        put_data(8'hF0);
        push_exp(rotl(8'hF0, 2), "R5 branch2");
        drain("R5 branch2 timeout");
        @(negedge clk);
        data_t = '0; data_f = '0;
        repeat (2) @(negedge clk);
        chk(res_t == rotl(8'hF0, 2) && res_f == ~rotl(8'hF0, 2), "R9 hold with select",
            32'(res_t), 32'(rotl(8'hF0, 2)));
        @(negedge clk);
        pick_t = '0; pick_f = '0;
        @(negedge clk);
        chk((res_t | res_f) == '0, "R8 clear after select drops", 32'({res_t, res_f}), 32'd0);

        // Select drops first while data holds: gate holds
        @(negedge clk);
        put_pick(1);
        put_data(8'h81);
        push_exp(rotl(8'h81, 1), "R5 branch1");
        drain("R5 branch1 timeout");
        @(negedge clk);
        pick_t = '0; pick_f = '0;
        @(negedge clk);
        chk(res_t == rotl(8'h81, 1), "R3 hold with data", 32'(res_t), 32'(rotl(8'h81, 1)));
        @(negedge clk);
        data_t = '0; data_f = '0;
        @(negedge clk);
        chk((res_t | res_f) == '0, "R3 clear when both low", 32'({res_t, res_f}), 32'd0);

        // Partial select (bit 1 NULL) enables nothing
        @(negedge clk);
        pick_t = 2'b01; pick_f = 2'b00;
        put_data(8'h33);
        repeat (3) @(negedge clk);
        chk((res_t | res_f) == '0, "R2 partial select", 32'({res_t, res_f}), 32'd0);
        go_null("R8 clear after partial");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule